// File: doc/BRIEF.md
# Last-Round Key Candidate Filter

This block screens guesses for four bytes of the final round key of a 128-bit block cipher, using one correct and one faulty ciphertext. A fault injected near the start of the eighth round leaves a fixed linear pattern among the state differences after the ninth-round column mixing. The pattern depends on how many state diagonals the fault touched. On every cycle with a valid strobe, the filter takes four correct ciphertext bytes, the four matching ciphertext differences (correct XOR faulty) and four candidate key bytes. For each byte it peels off the final round by applying the inverse S-box to both versions and XORing the results. It then checks whether the four recovered differences satisfy the relation of the selected fault model.

An external controller chooses the byte positions, enumerates the candidates, feeds one quadruple per cycle and gathers the ones that pass. The answer comes back one clock after the strobe as a registered pass flag with its own valid flag. Field multiplication by constants uses chains of the doubling step over GF(2^8) reduced by x^8+x^4+x^3+x+1 (0x11B). The inverse S-box is computed from the field inverse and the inverse affine map, so no lookup table is stored.

Top module: `fdf_key_filter`

## Requirements
- R1: For lane k (0..3), with ct, dif and key bytes taken from bits [8k+7:8k] of the matching bus, the recovered difference is a_k = ISB(ct XOR key) XOR ISB(ct XOR dif XOR key). ISB is the inverse of the standard AES S-box.
- R2: With mode 2'b00 (single faulty diagonal), a candidate passes only if a0 = 2·a1, a2 = a1 and a3 = 3·a1.
- R3: With mode 2'b01 (up to two faulty diagonals), a candidate passes only if a1 XOR a3 = a0 and 2·a1 XOR 3·a3 = 7·a2.
- R4: With mode 2'b10 (up to three faulty diagonals), a candidate passes only if 11·a0 XOR 13·a1 XOR 9·a2 XOR 14·a3 = 0.
- R5: Mode 2'b11 never produces a pass.
- R6: out_valid equals in_valid of the previous clock, and out_pass is the verdict for the quadruple presented on that previous clock. out_pass is 0 whenever out_valid is 0.
- R7: A quadruple whose four recovered differences are all zero fails in every mode. This includes an all-zero difference bus.
- R8: While rst_n is low, and for two clock edges after it rises, out_valid and out_pass are 0.
- R9: All products in R2 to R4 are taken in GF(2^8) modulo 0x11B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released through a synchronizer |
| in_valid | input | 1 | Quadruple on the data inputs is to be tested |
| mode | input | 2 | Fault model: 00 one diagonal, 01 two, 10 three, 11 reject all |
| ct_bytes | input | 32 | Four correct ciphertext bytes, lane k in bits [8k+7:8k] |
| dif_bytes | input | 32 | Four ciphertext differences, same lane layout |
| key_bytes | input | 32 | Four candidate key bytes, same lane layout |
| out_valid | output | 1 | A verdict is present |
| out_pass | output | 1 | The candidate satisfied the selected relation |

## Verification
The embedded assertions check on every clock the one-cycle alignment of out_valid with the strobe, that a pass never appears without valid, that mode 11 and all-zero differences never pass, and that a single-diagonal pass always comes with equal lane-1 and lane-2 differences. Whether the inverse S-box and the constant multipliers are correct can only be shown by the bench. It builds difference buses that meet each fault model for a known key, then sweeps whole key bytes through 256 values and compares every verdict with one computed from its own field arithmetic and table inversion.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int BUS_W  = BYTE_W * LANES;

  typedef enum logic [1:0] {
    FM_ONE_DIAG   = 2'b00,
    FM_TWO_DIAG   = 2'b01,
    FM_THREE_DIAG = 2'b10,
    FM_REJECT     = 2'b11
  } fault_mode_t;

  // doubling step modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mul2(input logic [7:0] v);
    return xtime(v);
  endfunction

  function automatic logic [7:0] mul3(input logic [7:0] v);
    return xtime(v) ^ v;
  endfunction

  function automatic logic [7:0] mul7(input logic [7:0] v);
    logic [7:0] d2, d4;
    d2 = xtime(v);
    d4 = xtime(d2);
    return d4 ^ d2 ^ v;
  endfunction

  function automatic logic [7:0] mul9(input logic [7:0] v);
    logic [7:0] d8;
    d8 = xtime(xtime(xtime(v)));
    return d8 ^ v;
  endfunction

  function automatic logic [7:0] mul11(input logic [7:0] v);
    logic [7:0] d2, d8;
    d2 = xtime(v);
    d8 = xtime(xtime(d2));
    return d8 ^ d2 ^ v;
  endfunction

  function automatic logic [7:0] mul13(input logic [7:0] v);
    logic [7:0] d4, d8;
    d4 = xtime(xtime(v));
    d8 = xtime(d4);
    return d8 ^ d4 ^ v;
  endfunction

  function automatic logic [7:0] mul14(input logic [7:0] v);
    logic [7:0] d2, d4, d8;
    d2 = xtime(v);
    d4 = xtime(d2);
    d8 = xtime(d4);
    return d8 ^ d4 ^ d2;
  endfunction

  // product of two variable field elements, used only for inversion
  function automatic logic [7:0] gf_prod(input logic [7:0] p, input logic [7:0] q);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = p;
    for (int i = 0; i < 8; i++) begin
      if (q[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

endpackage

// File: rtl/fdf_inv_sbox.sv
module fdf_inv_sbox
  import fdf_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);

  logic [7:0] pre;
  logic [7:0] e2, e3, e6, e7, e14, e15, e30, e31, e62, e63, e126, e127, e254;

  // undo the affine map of the forward substitution
  always_comb begin
    pre = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ 8'h05;
  end

  // field inverse as pre^254 through an addition chain (0 maps to 0)
  always_comb begin
    e2   = gf_prod(pre,  pre);
    e3   = gf_prod(e2,   pre);
    e6   = gf_prod(e3,   e3);
    e7   = gf_prod(e6,   pre);
    e14  = gf_prod(e7,   e7);
    e15  = gf_prod(e14,  pre);
    e30  = gf_prod(e15,  e15);
    e31  = gf_prod(e30,  pre);
    e62  = gf_prod(e31,  e31);
    e63  = gf_prod(e62,  pre);
    e126 = gf_prod(e63,  e63);
    e127 = gf_prod(e126, pre);
    e254 = gf_prod(e127, e127);
    dout = e254;
  end

endmodule

// File: rtl/fdf_lane.sv
module fdf_lane
  import fdf_pkg::*;
(
  input  logic [BYTE_W-1:0] ct,
  input  logic [BYTE_W-1:0] dif,
  input  logic [BYTE_W-1:0] key,
  output logic [BYTE_W-1:0] delta
);

  logic [BYTE_W-1:0] good_in, bad_in, good_out, bad_out;

  always_comb begin
    good_in = ct ^ key;
    bad_in  = ct ^ dif ^ key;
  end

  fdf_inv_sbox u_good (.din(good_in), .dout(good_out));
  fdf_inv_sbox u_bad  (.din(bad_in),  .dout(bad_out));

  always_comb begin
    delta = good_out ^ bad_out;
  end

endmodule

// File: rtl/fdf_relation.sv
module fdf_relation
  import fdf_pkg::*;
(
  input  logic [BUS_W-1:0] deltas,
  input  logic [1:0]       mode,
  output logic             ok
);

  logic [7:0] a0, a1, a2, a3;
  logic       nonzero, rel_one, rel_two, rel_three;

  always_comb begin
    a0 = deltas[7:0];
    a1 = deltas[15:8];
    a2 = deltas[23:16];
    a3 = deltas[31:24];
    nonzero   = |deltas;
    rel_one   = (a0 == mul2(a1)) && (a2 == a1) && (a3 == mul3(a1));
    rel_two   = ((a1 ^ a3) == a0) && ((mul2(a1) ^ mul3(a3)) == mul7(a2));
    rel_three = (mul11(a0) ^ mul13(a1) ^ mul9(a2) ^ mul14(a3)) == 8'h00;
  end

  always_comb begin
    unique case (fault_mode_t'(mode))
      FM_ONE_DIAG:   ok = nonzero && rel_one;
      FM_TWO_DIAG:   ok = nonzero && rel_two;
      FM_THREE_DIAG: ok = nonzero && rel_three;
      default:       ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/fdf_key_filter.sv
module fdf_key_filter
  import fdf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [BUS_W-1:0] ct_bytes,
  input  logic [BUS_W-1:0] dif_bytes,
  input  logic [BUS_W-1:0] key_bytes,
  output logic             out_valid,
  output logic             out_pass
);

  // reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // per-lane inverse of the last round
  logic [BUS_W-1:0] deltas;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      fdf_lane u_lane (
        .ct    (ct_bytes [k*BYTE_W +: BYTE_W]),
        .dif   (dif_bytes[k*BYTE_W +: BYTE_W]),
        .key   (key_bytes[k*BYTE_W +: BYTE_W]),
        .delta (deltas   [k*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  logic rel_ok;

  fdf_relation u_rel (
    .deltas (deltas),
    .mode   (mode),
    .ok     (rel_ok)
  );

  // output stage: next-state and register processes
  logic valid_d, pass_d, pass_en;
  logic valid_q, pass_q;

  always_comb begin
    valid_d = in_valid;
    pass_en = in_valid | pass_q;
    pass_d  = in_valid & rel_ok;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (pass_en) pass_q <= pass_d;
    end
  end

  assign out_valid = valid_q;
  assign out_pass  = pass_q;

  // R6: verdict follows the strobe by one clock
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R6: no pass without valid
  a_r6_pass_has_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_pass |-> out_valid);

  // R5: reject mode never passes
  a_r5_reject_mode: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && mode == 2'b11) |=> !out_pass);

  // R7: zero differences never pass
  a_r7_zero_diff: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && dif_bytes == '0) |=> !out_pass);

  // R2: single-diagonal acceptance implies equal lane-1/lane-2 differences
  a_r2_one_diag_lanes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && mode == 2'b00 && rel_ok) |-> (deltas[23:16] == deltas[15:8]));

  // R8: outputs quiet while the internal reset holds
  always_comb begin
    if (!rst_int_n) begin
      a_r8_reset_quiet: assert (!out_valid && !out_pass);
    end
  end

endmodule

// File: tb/fdf_key_filter_test.sv
`timescale 1ns/1ps
module fdf_key_filter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic [31:0] ct_bytes, dif_bytes, key_bytes;
  logic        out_valid, out_pass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] fwd [256];
  logic [7:0] inv_t [256];

  always #2 clk = ~clk;

  fdf_key_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .ct_bytes(ct_bytes), .dif_bytes(dif_bytes), .key_bytes(key_bytes),
    .out_valid(out_valid), .out_pass(out_pass)
  );

  function automatic logic [7:0] fmul(input logic [7:0] p, input logic [7:0] q);
    logic [15:0] wide;
    wide = 16'h0;
    for (int i = 0; i < 8; i++) if (q[i]) wide = wide ^ (16'(p) << i);
    for (int i = 15; i >= 8; i--) if (wide[i]) wide = wide ^ (16'h011b << (i - 8));
    return wide[7:0];
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] lane_delta(input logic [31:0] x, d, k, input int ln);
    logic [7:0] xb, db, kb;
    xb = x[ln*8 +: 8]; db = d[ln*8 +: 8]; kb = k[ln*8 +: 8];
    return inv_t[xb ^ kb] ^ inv_t[xb ^ db ^ kb];
  endfunction

  function automatic bit expect_pass(input logic [1:0] m, input logic [31:0] x, d, k);
    logic [7:0] a0, a1, a2, a3;
    a0 = lane_delta(x, d, k, 0); a1 = lane_delta(x, d, k, 1);
    a2 = lane_delta(x, d, k, 2); a3 = lane_delta(x, d, k, 3);
    if ({a0, a1, a2, a3} == 32'h0) return 1'b0;
    case (m)
      2'b00: return (a0 == fmul(2, a1)) && (a2 == a1) && (a3 == fmul(3, a1));
      2'b01: return ((a1 ^ a3) == a0) && ((fmul(2, a1) ^ fmul(3, a3)) == fmul(7, a2));
      2'b10: return (fmul(11, a0) ^ fmul(13, a1) ^ fmul(9, a2) ^ fmul(14, a3)) == 8'h00;
      default: return 1'b0;
    endcase
  endfunction

  // difference bus that yields the wanted lane differences under key k
  function automatic logic [31:0] build_dif(input logic [31:0] x, k, input logic [31:0] want);
    logic [31:0] r;
    for (int ln = 0; ln < 4; ln++) begin
      logic [7:0] xb, kb;
      xb = x[ln*8 +: 8]; kb = k[ln*8 +: 8];
      r[ln*8 +: 8] = fwd[inv_t[xb ^ kb] ^ want[ln*8 +: 8]] ^ xb ^ kb;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [31:0] x, d, k, input string req);
    bit e;
    e = expect_pass(m, x, d, k);
    @(negedge clk);
    mode = m; ct_bytes = x; dif_bytes = d; key_bytes = k; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " valid"}, int'(out_valid), 1);
    check(out_pass === e, req, int'(out_pass), int'(e));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, k, d, w;
    logic [7:0] f1, f6, f11;

    // bench tables: inverse by search, forward affine, then invert
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'h00;
      for (int u = 1; u < 256; u++) if (fmul(8'(v), 8'(u)) == 8'h01) b = 8'(u);
      fwd[v] = b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
    end
    for (int v = 0; v < 256; v++) inv_t[fwd[v]] = 8'(v);

    rst_n = 1'b0; in_valid = 1'b0; mode = 2'b00;
    ct_bytes = '0; dif_bytes = '0; key_bytes = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_pass === 1'b0, "R8 in reset", int'({out_valid, out_pass}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 sync release", int'(out_valid), 0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R6 idle", int'(out_valid), 0);

    x = 32'h3c_a1_5e_07;
    k = 32'h9b_12_d4_6f;

    // R2: one faulty diagonal, F = 0x5a
    f1 = 8'h5a;
    w  = {fmul(3, f1), f1, f1, fmul(2, f1)};
    d  = build_dif(x, k, w);
    run(2'b00, x, d, k, "R2 R1 true key");
    check(expect_pass(2'b00, x, d, k) == 1'b1, "R1 bench build", 0, 1);
    for (int g = 0; g < 256; g++) run(2'b00, x, d, {k[31:8], 8'(g)}, "R2 sweep lane0");
    for (int g = 0; g < 256; g++) run(2'b00, x, d, {k[31:24], 8'(g), k[15:0]}, "R2 sweep lane2");

    // R3: two diagonals
    f1 = 8'hc3; f6 = 8'h2e;
    w  = {fmul(3, f1) ^ f6, f1 ^ f6, f1 ^ fmul(2, f6), fmul(2, f1) ^ fmul(3, f6)};
    d  = build_dif(x, k, w);
    run(2'b01, x, d, k, "R3 true key");
    for (int g = 0; g < 256; g++) run(2'b01, x, d, {k[31:8], 8'(g)}, "R3 R9 sweep lane0");
    for (int g = 0; g < 256; g++) run(2'b01, x, d, {8'(g), k[23:0]}, "R3 sweep lane3");

    // R4: three diagonals
    f1 = 8'h71; f6 = 8'h0d; f11 = 8'hb8;
    w  = {fmul(3, f1) ^ f6 ^ f11, f1 ^ f6 ^ fmul(2, f11),
          f1 ^ fmul(2, f6) ^ fmul(3, f11), fmul(2, f1) ^ fmul(3, f6) ^ f11};
    d  = build_dif(x, k, w);
    run(2'b10, x, d, k, "R4 true key");
    for (int g = 0; g < 256; g++) run(2'b10, x, d, {k[31:16], 8'(g), k[7:0]}, "R4 R9 sweep lane1");

    // R5: reject mode on the same passing pair
    for (int g = 0; g < 64; g++) run(2'b11, x, d, {k[31:8], 8'(g)}, "R5 reject mode");
    check(expect_pass(2'b11, x, d, k) == 1'b0, "R5 bench", 1, 0);

    // R7: zero differences in every mode, and an unsatisfied pair
    for (int m = 0; m < 4; m++) run(2'(m), x, 32'h0, k, "R7 zero diff");
    for (int m = 0; m < 4; m++) run(2'(m), 32'hffff_0000, 32'h0, 32'h1234_5678, "R7 zero diff alt");

    // R6: valid drops the cycle after a lone strobe
    @(negedge clk);
    check(out_valid === 1'b0 && out_pass === 1'b0, "R6 after strobe", int'({out_valid, out_pass}), 0);

    // R6: back-to-back strobes
    @(negedge clk);
    mode = 2'b00; ct_bytes = x; key_bytes = k;
    dif_bytes = build_dif(x, k, {fmul(3, 8'h11), 8'h11, 8'h11, fmul(2, 8'h11)});
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b1 && out_pass === 1'b1, "R6 first of pair", int'({out_valid, out_pass}), 3);
    dif_bytes = 32'h0;
    @(negedge clk);
    check(out_valid === 1'b1 && out_pass === 1'b0, "R6 second of pair", int'({out_valid, out_pass}), 2);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 back idle", int'(out_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule